// File: doc/BRIEF.md
# Bus Transfer Unit for a Microprogrammed 16-bit Datapath

This block is the register-transfer part of a small microcoded computer. Every clock cycle the microcode supplies two 3-bit selectors. The source selector picks which value drives the shared 16-bit bus. The destination selector picks which storage element captures that value at the next rising edge. The block holds the instruction register, an 8-bit program counter, an 8-bit memory address register, a helper register, four general registers and a 256-word program memory.

The accumulator is not held here. Its value enters on `ar_in`, and the ALU, sequencer and loop counter read the bus from `bus_out`. A register-select bit picks which instruction-register field gives the general-register index. A count bit steps the program counter.

Source code 7 places the low 16 bits of the microword on the bus. In that cycle the block holds every register and the memory. It also drops `side_fx_en`, so the external loop counter knows it must skip its action too. The testbench, or an external loader, can preload the program memory through a separate load port.

Top module: `bus_xfer_unit`

## Requirements
- R1: While `to_sel` is 0..6, `bus_out` combinationally shows: 0 → 0xFFFF, 1 → IR, 2 → program memory word at address ASR, 3 → PC zero-extended to 16 bits, 4 → `ar_in`, 5 → HR, 6 → the selected general register.
- R2: While `to_sel` is 7, `bus_out` equals `uword_imm`. At the following edge IR, PC, ASR, HR, the general registers and the program memory keep their values, whatever `from_sel` and `pc_inc` are.
- R3: When `to_sel` is not 7, the edge stores the bus value according to `from_sel`: 1 → IR, 2 → program memory at ASR, 3 → PC gets bus bits 7:0, 5 → HR, 6 → the selected general register. Codes 0, 4 and 7 load ASR with bus bits 7:0.
- R4: IR bits 11:10 form the GRx index and bits 9:8 form the M index. With `gr_sel_m` high the general register used for reading and writing is the one numbered by M; with it low, the one numbered by GRx.
- R5: With `pc_inc` high and `to_sel` not 7, PC becomes its previous value plus one, modulo 256. This increment wins over a bus write to PC in the same cycle.
- R6: All values read in a cycle are those held before the edge, and all writes of that cycle land together on the edge. For example, a PC read onto the bus in a cycle that also increments PC shows the old PC.
- R7: The program memory is written on the clock edge and read combinationally, so a word stored in one cycle is visible on the bus in the next cycle.
- R8: With `ld_en` high, the edge writes `ld_data` into program memory at `ld_addr`. Any bus write to program memory in that same cycle is dropped.
- R9: With `rst_n` low at a rising edge, IR, PC, ASR, HR and all general registers become zero. The program memory contents are kept.
- R10: `side_fx_en` is high exactly when `to_sel` is not 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| to_sel | input | 3 | Bus source code |
| from_sel | input | 3 | Bus destination code |
| gr_sel_m | input | 1 | General-register index from M (1) or GRx (0) |
| pc_inc | input | 1 | Step PC by one |
| uword_imm | input | 16 | Low 16 bits of the current microword |
| ar_in | input | 16 | Accumulator value from the ALU |
| ld_en | input | 1 | Program-memory preload strobe |
| ld_addr | input | 8 | Preload address |
| ld_data | input | 16 | Preload data |
| bus_out | output | 16 | Current bus value |
| side_fx_en | output | 1 | High when the cycle's transfers take effect |
| ir_out | output | 16 | Instruction register |
| pc_out | output | 8 | Program counter |
| asr_out | output | 8 | Memory address register |
| hr_out | output | 16 | Helper register |

## Verification
Three pairs of actions can fall in the same cycle. The program counter can be incremented while the bus also targets it. The memory can be preloaded while the bus also writes it. The immediate source can be selected while a destination and an increment are also requested. Each pair is provoked by setting both controls in one vector. The result is judged at the ports after the edge: PC must show old+1, including the wrap from 0xFF to 0x00, and the memory word must read back as the preload value. After an immediate cycle, all registers must be unchanged. One vector also reads PC onto the bus while incrementing it, to confirm that the bus shows the pre-edge value.

// File: rtl/bxu_pkg.sv
// Shared constants and code types of the bus transfer unit.
// Assumes a 16-bit word with the instruction-register field layout fixed
// at GRx = bits 11:10 and M = bits 9:8.
package bxu_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned PM_ADDR_W = 8;
    localparam int unsigned GR_COUNT  = 4;
    localparam int unsigned SEL_W     = 3;

    localparam int unsigned IR_GRX_LSB = 10;
    localparam int unsigned IR_M_LSB   = 8;

    // Bus source codes, numbered as the microword encodes them.
    typedef enum logic [SEL_W-1:0] {
        SRC_ONES = 3'd0,
        SRC_IR   = 3'd1,
        SRC_PMEM = 3'd2,
        SRC_PC   = 3'd3,
        SRC_ACC  = 3'd4,
        SRC_HR   = 3'd5,
        SRC_GR   = 3'd6,
        SRC_IMM  = 3'd7
    } bus_src_e;

    // Bus destination codes; three codes share the address-register target.
    typedef enum logic [SEL_W-1:0] {
        DST_ADR_A = 3'd0,
        DST_IR    = 3'd1,
        DST_PMEM  = 3'd2,
        DST_PC    = 3'd3,
        DST_ADR_B = 3'd4,
        DST_HR    = 3'd5,
        DST_GR    = 3'd6,
        DST_ADR_C = 3'd7
    } bus_dst_e;

endpackage

// File: rtl/bxu_src_mux.sv
// Bus source multiplexer: turns the source code into the bus value.
// Purely combinational; the program counter is zero-extended to word width.
module bxu_src_mux
    import bxu_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned ADDR_W = PM_ADDR_W
) (
    input  bus_src_e              src,
    input  logic [DATA_W-1:0]     ir_val,
    input  logic [DATA_W-1:0]     pmem_val,
    input  logic [ADDR_W-1:0]     pc_val,
    input  logic [DATA_W-1:0]     acc_val,
    input  logic [DATA_W-1:0]     hr_val,
    input  logic [DATA_W-1:0]     gr_val,
    input  logic [DATA_W-1:0]     imm_val,
    output logic [DATA_W-1:0]     bus
);

    localparam int unsigned PAD_W = DATA_W - ADDR_W;

    // Select one driver for the shared bus.
    always_comb begin
        case (src)
            SRC_ONES: bus = '1;
            SRC_IR:   bus = ir_val;
            SRC_PMEM: bus = pmem_val;
            SRC_PC:   bus = {{PAD_W{1'b0}}, pc_val};
            SRC_ACC:  bus = acc_val;
            SRC_HR:   bus = hr_val;
            SRC_GR:   bus = gr_val;
            SRC_IMM:  bus = imm_val;
            default:  bus = '0;
        endcase
    end

endmodule

// File: rtl/bxu_gr_file.sv
// General register file: NUM_GR words, one write port, one read port.
// Write is synchronous with synchronous active-low clear; read is combinational.
module bxu_gr_file
    import bxu_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned NUM_GR = GR_COUNT,
    localparam int unsigned IDX_W = (NUM_GR > 1) ? $clog2(NUM_GR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] gr_vec [NUM_GR];

    for (genvar g = 0; g < NUM_GR; g++) begin : g_reg
        logic [DATA_W-1:0] q;

        // Hold one general register; load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                q <= wr_data;
            end
        end

        assign gr_vec[g] = q;
    end

    assign rd_data = gr_vec[rd_idx];

endmodule

// File: rtl/bxu_pmem.sv
// Program memory: 2**ADDR_W words, synchronous write, combinational read.
// The preload port has priority and blocks the bus write for that cycle.
// Contents are not cleared by reset.
module bxu_pmem
    import bxu_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned ADDR_W = PM_ADDR_W,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per edge; the preload path wins.
    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (bus_we) begin
            mem[bus_addr] <= bus_data;
        end
    end

    assign rd_data = mem[bus_addr];

endmodule

// File: rtl/bus_xfer_unit.sv
// Bus transfer unit: drives the shared bus from one source and loads one
// destination per cycle. It holds IR, PC, ASR, HR, the general registers and
// the program memory. Source code 7 (microword immediate) freezes every
// register and memory write for the cycle. All writes use pre-edge values.
module bus_xfer_unit
    import bxu_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned ADDR_W = PM_ADDR_W,
    parameter int unsigned NUM_GR = GR_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        to_sel,
    input  logic [2:0]        from_sel,
    input  logic              gr_sel_m,
    input  logic              pc_inc,
    input  logic [DATA_W-1:0] uword_imm,
    input  logic [DATA_W-1:0] ar_in,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] bus_out,
    output logic              side_fx_en,
    output logic [DATA_W-1:0] ir_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] asr_out,
    output logic [DATA_W-1:0] hr_out
);

    localparam int unsigned IDX_W = (NUM_GR > 1) ? $clog2(NUM_GR) : 1;

    bus_src_e          src;
    bus_dst_e          dst;
    logic              xfer_en;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] ir_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] asr_q;
    logic [DATA_W-1:0] hr_q;
    logic [DATA_W-1:0] pmem_rd;
    logic [DATA_W-1:0] gr_rd;
    logic [IDX_W-1:0]  gr_idx;
    logic              ir_we;
    logic              pc_we;
    logic              asr_we;
    logic              hr_we;
    logic              gr_we;
    logic              pmem_we;

    assign src     = bus_src_e'(to_sel);
    assign dst     = bus_dst_e'(from_sel);
    assign xfer_en = (src != SRC_IMM);

    // Pick the general-register index from the M or the GRx field of IR.
    always_comb begin
        if (gr_sel_m) begin
            gr_idx = ir_q[IR_M_LSB +: IDX_W];
        end else begin
            gr_idx = ir_q[IR_GRX_LSB +: IDX_W];
        end
    end

    // Decode the destination code into one write strobe per target.
    always_comb begin
        ir_we   = 1'b0;
        pc_we   = 1'b0;
        asr_we  = 1'b0;
        hr_we   = 1'b0;
        gr_we   = 1'b0;
        pmem_we = 1'b0;
        if (xfer_en) begin
            case (dst)
                DST_IR:   ir_we   = 1'b1;
                DST_PMEM: pmem_we = 1'b1;
                DST_PC:   pc_we   = 1'b1;
                DST_HR:   hr_we   = 1'b1;
                DST_GR:   gr_we   = 1'b1;
                default:  asr_we  = 1'b1;
            endcase
        end
    end

    bxu_src_mux #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) src_mux_i (
        .src      (src),
        .ir_val   (ir_q),
        .pmem_val (pmem_rd),
        .pc_val   (pc_q),
        .acc_val  (ar_in),
        .hr_val   (hr_q),
        .gr_val   (gr_rd),
        .imm_val  (uword_imm),
        .bus      (bus)
    );

    bxu_gr_file #(
        .DATA_W (DATA_W),
        .NUM_GR (NUM_GR)
    ) gr_file_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gr_we),
        .wr_idx  (gr_idx),
        .wr_data (bus),
        .rd_idx  (gr_idx),
        .rd_data (gr_rd)
    );

    bxu_pmem #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) pmem_i (
        .clk      (clk),
        .bus_we   (pmem_we),
        .bus_addr (asr_q),
        .bus_data (bus),
        .ld_we    (ld_en),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .rd_data  (pmem_rd)
    );

    // Instruction register: load the full bus word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ir_we) begin
            ir_q <= bus;
        end
    end

    // Program counter: increment beats a bus load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (xfer_en && pc_inc) begin
            pc_q <= pc_q + ADDR_W'(1);
        end else if (pc_we) begin
            pc_q <= bus[ADDR_W-1:0];
        end
    end

    // Address register: low bus bits on any of its three codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asr_q <= '0;
        end else if (asr_we) begin
            asr_q <= bus[ADDR_W-1:0];
        end
    end

    // Helper register: load the full bus word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hr_q <= '0;
        end else if (hr_we) begin
            hr_q <= bus;
        end
    end

    assign bus_out    = bus;
    assign side_fx_en = xfer_en;
    assign ir_out     = ir_q;
    assign pc_out     = pc_q;
    assign asr_out    = asr_q;
    assign hr_out     = hr_q;

endmodule

// File: rtl/bxu_checker.sv
// Temporal checks on the bus transfer unit, attached by bind.
module bxu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  to_sel,
    input logic [2:0]  from_sel,
    input logic        pc_inc,
    input logic [15:0] bus_out,
    input logic [15:0] ir_out,
    input logic [7:0]  pc_out,
    input logic [7:0]  asr_out,
    input logic [15:0] hr_out
);

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && to_sel != 3'd7) |=> (pc_out == $past(pc_out) + 8'd1));

    // R2
    imm_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_sel == 3'd7) |=> ($stable(ir_out) && $stable(pc_out)
                              && $stable(asr_out) && $stable(hr_out)));

    // R3
    asr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_sel != 3'd7 && (from_sel == 3'd0 || from_sel == 3'd4 || from_sel == 3'd7))
        |=> (asr_out == $past(bus_out[7:0])));

    // R3
    ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_sel != 3'd7 && from_sel == 3'd1) |=> (ir_out == $past(bus_out)));

    // R6
    hr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (from_sel != 3'd5) |=> (hr_out == $past(hr_out)));

endmodule

bind bus_xfer_unit bxu_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .to_sel   (to_sel),
    .from_sel (from_sel),
    .pc_inc   (pc_inc),
    .bus_out  (bus_out),
    .ir_out   (ir_out),
    .pc_out   (pc_out),
    .asr_out  (asr_out),
    .hr_out   (hr_out)
);

// File: tb/bus_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module bus_xfer_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  to_sel = 3'd7;
    logic [2:0]  from_sel = 3'd0;
    logic        gr_sel_m = 1'b0;
    logic        pc_inc = 1'b0;
    logic [15:0] uword_imm = 16'h0000;
    logic [15:0] ar_in = 16'h0000;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = 8'h00;
    logic [15:0] ld_data = 16'h0000;
    logic [15:0] bus_out;
    logic        side_fx_en;
    logic [15:0] ir_out;
    logic [7:0]  pc_out;
    logic [7:0]  asr_out;
    logic [15:0] hr_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_xfer_unit dut_i (
        .clk (clk), .rst_n (rst_n), .to_sel (to_sel), .from_sel (from_sel),
        .gr_sel_m (gr_sel_m), .pc_inc (pc_inc), .uword_imm (uword_imm),
        .ar_in (ar_in), .ld_en (ld_en), .ld_addr (ld_addr), .ld_data (ld_data),
        .bus_out (bus_out), .side_fx_en (side_fx_en), .ir_out (ir_out),
        .pc_out (pc_out), .asr_out (asr_out), .hr_out (hr_out)
    );

    typedef struct packed {
        logic [2:0]  t;
        logic [2:0]  f;
        logic        s;
        logic        p;
        logic [15:0] imm;
        logic [15:0] ar;
        logic [15:0] e_bus;
        logic [15:0] e_ir;
        logic [7:0]  e_pc;
        logic [7:0]  e_asr;
        logic [15:0] e_hr;
    } vec_t;

    localparam int NVEC = 17;
    // Starts from reset state with pmem[0x10] = 0x1234 preloaded.
    localparam vec_t TBL [NVEC] = '{
        '{3'd4, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0010, 16'h0010, 16'h0000, 8'h00, 8'h10, 16'h0000}, // R1 R3
        '{3'd2, 3'd1, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h1234, 16'h1234, 8'h00, 8'h10, 16'h0000}, // R7 R3
        '{3'd0, 3'd6, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 16'h1234, 8'h00, 8'h10, 16'h0000}, // R4 GR2 <= FFFF
        '{3'd6, 3'd5, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 16'h1234, 8'h00, 8'h10, 16'hFFFF}, // R4 via M
        '{3'd6, 3'd5, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h1234, 8'h00, 8'h10, 16'h0000}, // R4 via GRx
        '{3'd7, 3'd5, 1'b0, 1'b1, 16'hABCD, 16'h0000, 16'hABCD, 16'h1234, 8'h00, 8'h10, 16'h0000}, // R2 freeze
        '{3'd4, 3'd3, 1'b0, 1'b0, 16'h0000, 16'h01FE, 16'h01FE, 16'h1234, 8'hFE, 8'h10, 16'h0000}, // R3 PC low byte
        '{3'd3, 3'd5, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h00FE, 16'h1234, 8'hFF, 8'h10, 16'h00FE}, // R6 R5
        '{3'd4, 3'd3, 1'b0, 1'b1, 16'h0000, 16'h0042, 16'h0042, 16'h1234, 8'h00, 8'h10, 16'h00FE}, // R5 wrap+priority
        '{3'd4, 3'd2, 1'b0, 1'b0, 16'h0000, 16'h5678, 16'h5678, 16'h1234, 8'h00, 8'h10, 16'h00FE}, // R7 write
        '{3'd2, 3'd4, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h5678, 16'h1234, 8'h00, 8'h78, 16'h00FE}, // R7 readback, R3 code 4
        '{3'd1, 3'd7, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h1234, 16'h1234, 8'h00, 8'h34, 16'h00FE}, // R1 R3 code 7
        '{3'd5, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h00FE, 16'h1234, 8'h00, 8'hFE, 16'h00FE}, // R1 HR source
        '{3'd0, 3'd1, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 8'h00, 8'hFE, 16'h00FE}, // R1 ones, R4 fields=3
        '{3'd6, 3'd5, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 8'h00, 8'hFE, 16'h0000}, // R4 GR3 empty
        '{3'd4, 3'd6, 1'b1, 1'b0, 16'h0000, 16'h00FF, 16'h00FF, 16'hFFFF, 8'h00, 8'hFE, 16'h0000}, // R4 GR3 <= 00FF
        '{3'd6, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h00FF, 16'hFFFF, 8'h00, 8'hFF, 16'h0000}  // R4 read GR3
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [2:0] t, input logic [2:0] f, input logic s,
                         input logic p, input logic [15:0] im, input logic [15:0] a);
        @(negedge clk);
        to_sel = t; from_sel = f; gr_sel_m = s; pc_inc = p; uword_imm = im; ar_in = a;
    endtask

    task automatic settle_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state, R10 idle flag low
        chk("R9 reset IR", ir_out, 16'h0000);
        chk("R9 reset PC", {8'h00, pc_out}, 16'h0000);
        chk("R9 reset ASR", {8'h00, asr_out}, 16'h0000);
        chk("R9 reset HR", hr_out, 16'h0000);
        chk("R10 flag idle", {15'd0, side_fx_en}, 16'h0000);

        // R8 preload pmem[0x10]
        @(negedge clk);
        ld_en = 1'b1; ld_addr = 8'h10; ld_data = 16'h1234;
        @(negedge clk);
        ld_en = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].t, TBL[i].f, TBL[i].s, TBL[i].p, TBL[i].imm, TBL[i].ar);
            #1;
            chk($sformatf("R1/R2 vec %0d bus", i), bus_out, TBL[i].e_bus);
            chk($sformatf("R10 vec %0d flag", i), {15'd0, side_fx_en},
                {15'd0, (TBL[i].t != 3'd7)});
            settle_edge();
            chk($sformatf("R3 vec %0d IR", i), ir_out, TBL[i].e_ir);
            chk($sformatf("R5 vec %0d PC", i), {8'h00, pc_out}, {8'h00, TBL[i].e_pc});
            chk($sformatf("R3 vec %0d ASR", i), {8'h00, asr_out}, {8'h00, TBL[i].e_asr});
            chk($sformatf("R6 vec %0d HR", i), hr_out, TBL[i].e_hr);
        end

        // R8: preload and bus write to the same address in one cycle (ASR = FF)
        drive(3'd4, 3'd2, 1'b0, 1'b0, 16'h0000, 16'h9999);
        ld_en = 1'b1; ld_addr = 8'hFF; ld_data = 16'h4242;
        settle_edge();
        drive(3'd2, 3'd7, 1'b0, 1'b0, 16'h0000, 16'h0000);
        ld_en = 1'b0;
        #1;
        chk("R8 preload wins", bus_out, 16'h4242);
        settle_edge();
        chk("R3 ASR from bus low byte", {8'h00, asr_out}, 16'h0042);

        // R9: mid-run reset clears registers, keeps memory
        drive(3'd7, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000);
        rst_n = 1'b0;
        settle_edge();
        chk("R9 mid reset ASR", {8'h00, asr_out}, 16'h0000);
        chk("R9 mid reset IR", ir_out, 16'h0000);
        chk("R9 mid reset HR", hr_out, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'd0, 3'd1, 1'b0, 1'b0, 16'h0000, 16'h0000);
        settle_edge();
        drive(3'd6, 3'd5, 1'b0, 1'b0, 16'h0000, 16'h0000);
        #1;
        chk("R9 GR3 cleared", bus_out, 16'h0000);
        settle_edge();
        drive(3'd4, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0010);
        settle_edge();
        drive(3'd2, 3'd5, 1'b0, 1'b0, 16'h0000, 16'h0000);
        #1;
        chk("R9 memory kept", bus_out, 16'h5678);
        settle_edge();
        drive(3'd7, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000);
        settle_edge();

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule